// File: doc/BRIEF.md
# Sub-Word Write Packer with Optional Byte Reversal

This block takes writes of one, two or four bytes aimed at a single data register and gathers them into 32-bit words for a downstream word consumer. Narrow writes fill the word starting at the least significant byte. A buffer therefore packs to the same word whether it arrives as bytes, halfwords or whole words. When a word is complete, the block can reverse its four bytes, so that the first byte of the buffer becomes the most significant byte seen by the consumer. It then presents the word with a single-cycle valid pulse.

The write side has no back-pressure: every write is taken in the cycle it is presented. The consumer has a level `out_ready` and no way to stall the output. A write that arrives while `out_ready` is low is dropped. It also sets a sticky error flag, which stays set until software writes a one to clear it. A `clear` input returns packing to byte lane 0, and a small configuration port loads the byte-reversal enable.

Top module: `subword_packer`

## Requirements
- R1: After reset, `word_valid` and `err_flag` are 0, packing starts at byte lane 0, and byte reversal is enabled.
- R2: A word write (`wr_size`=2) with `out_ready` high completes a word on its own. `word_valid` is high for exactly the next cycle, with `word_data` holding the result.
- R3: Halfword writes (`wr_size`=1) fill bits 15:0 first and then bits 31:16. The word is issued after the second halfword. The halfword is taken from `wr_data[31:16]` when `wr_addr[1]`=1, and from `wr_data[15:0]` otherwise.
- R4: Byte writes (`wr_size`=0) fill bits 7:0, 15:8, 23:16 and 31:24 in arrival order. The word is issued after the fourth byte. The byte is taken from `wr_data[8*wr_addr +: 8]`.
- R5: When byte reversal is on, the packed word {b3,b2,b1,b0} is presented as {b0,b1,b2,b3}. When it is off, the word is presented unchanged. A `cfg_we` pulse loads `cfg_swap` into the enable, and the new value applies to words completed from the next cycle on.
- R6: A write with `wr_size`=3 is ignored. It does not advance packing, does not issue a word and does not set the error flag.
- R7: A valid-size write while `out_ready` is low sets `err_flag` in the next cycle. The write is discarded, and the packing position does not advance.
- R8: `err_flag` holds until an `err_clr` pulse clears it. If a new error and `err_clr` occur in the same cycle, the flag is set.
- R9: A `clear` pulse returns packing to byte lane 0 and discards any partly packed word. A write in the same cycle as `clear` is dropped.
- R10: A word write that arrives part-way through a word discards the partial bytes, issues the written word, and restarts packing at lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Restart packing at lane 0 |
| cfg_we | input | 1 | Load byte-reversal enable |
| cfg_swap | input | 1 | Enable value loaded by cfg_we |
| err_clr | input | 1 | Write-one-to-clear for err_flag |
| err_flag | output | 1 | Sticky write-while-busy error |
| wr_valid | input | 1 | Write present this cycle |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_addr | input | 2 | Low address bits that pick the lane |
| wr_data | input | 32 | Write data |
| out_ready | input | 1 | Consumer can take data |
| word_valid | output | 1 | One-cycle pulse when a word is issued |
| word_data | output | 32 | Issued word, valid with word_valid |

## Verification
The hardest situation to reach is an error in the middle of a word. A byte write must be rejected while earlier bytes of the same word are already held, and the next accepted byte must still land in the lane after the last good one. The bench reaches this by dropping `out_ready` between the second and third byte writes of a word. It then restores `out_ready` and checks the final packed word, which shows that the rejected byte left no trace. The same-cycle race between a new error and `err_clr` is driven directly, and the flag is read back afterwards.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/spk_lane_pick.sv
module spk_lane_pick #(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int POS_W  = $clog2(NB),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [POS_W-1:0]  addr,
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        byte_val,
  output logic [HALF_W-1:0] half_val
);
  // byte lane chosen by the full low address, half lane by its top bit
  always_comb begin
    byte_val = data[int'(addr)*8 +: 8];
    half_val = data[int'(addr[POS_W-1])*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/spk_pack_accum.sv
module spk_pack_accum
  import spk_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int POS_W  = $clog2(NB),
  localparam int HALF_W = DATA_W / 2,
  localparam int HB     = NB / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire,
  input  xfer_size_e        size,
  input  logic [7:0]        byte_val,
  input  logic [HALF_W-1:0] half_val,
  input  logic [DATA_W-1:0] word_val,
  output logic              done,
  output logic [DATA_W-1:0] packed_word
);
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] acc_q;
  logic [POS_W:0]    inc;
  logic [POS_W:0]    sum;

  always_comb begin
    case (size)
      SZ_BYTE: inc = (POS_W+1)'(1);
      SZ_HALF: inc = (POS_W+1)'(HB);
      default: inc = (POS_W+1)'(NB);
    endcase
    sum  = {1'b0, pos_q} + inc;
    done = fire && ((size == SZ_WORD) || (sum >= (POS_W+1)'(NB)));
  end

  // per-lane merge of the incoming write into the held partial word
  for (genvar j = 0; j < NB; j++) begin : g_lane
    always_comb begin
      if (size == SZ_WORD)
        packed_word[8*j +: 8] = word_val[8*j +: 8];
      else if (size == SZ_BYTE && int'(pos_q) == j)
        packed_word[8*j +: 8] = byte_val;
      else if (size == SZ_HALF && (j / HB) == (int'(pos_q) / HB))
        packed_word[8*j +: 8] = half_val[8*(j % HB) +: 8];
      else
        packed_word[8*j +: 8] = acc_q[8*j +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      acc_q <= '0;
    end else if (clear) begin
      pos_q <= '0;
      acc_q <= '0;
    end else if (fire) begin
      if (done) begin
        pos_q <= '0;
        acc_q <= '0;
      end else begin
        pos_q <= sum[POS_W-1:0];
        acc_q <= packed_word;
      end
    end
  end

  AST_CLEAR_TO_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pos_q == '0)); // R9
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clear) |=> $stable(pos_q)); // R7
  AST_WORD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clear && size == SZ_WORD) |=> (pos_q == '0)); // R10
endmodule

// File: rtl/spk_byte_order.sv
module spk_byte_order #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rev;
  for (genvar j = 0; j < NB; j++) begin : g_rev
    assign rev[8*j +: 8] = din[8*(NB-1-j) +: 8];
  end
  assign dout = en ? rev : din;
endmodule

// File: rtl/spk_err_flag.sv
module spk_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R8
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag); // R8
endmodule

// File: rtl/subword_packer.sv
module subword_packer
  import spk_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int POS_W  = $clog2(NB),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cfg_we,
  input  logic              cfg_swap,
  input  logic              err_clr,
  output logic              err_flag,
  input  logic              wr_valid,
  input  logic [1:0]        wr_size,
  input  logic [POS_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              out_ready,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  xfer_size_e        size;
  logic              size_ok;
  logic              fire;
  logic              busy_hit;
  logic              swap_q;
  logic [7:0]        byte_val;
  logic [HALF_W-1:0] half_val;
  logic              done;
  logic [DATA_W-1:0] packed_word;
  logic [DATA_W-1:0] ordered;

  assign size     = xfer_size_e'(wr_size);
  assign size_ok  = (size != SZ_RSVD);
  assign busy_hit = wr_valid && size_ok && !out_ready;
  assign fire     = wr_valid && size_ok && out_ready && !clear;

  spk_lane_pick #(.DATA_W(DATA_W)) u_pick (
    .addr     (wr_addr),
    .data     (wr_data),
    .byte_val (byte_val),
    .half_val (half_val)
  );

  spk_pack_accum #(.DATA_W(DATA_W)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .fire        (fire),
    .size        (size),
    .byte_val    (byte_val),
    .half_val    (half_val),
    .word_val    (wr_data),
    .done        (done),
    .packed_word (packed_word)
  );

  spk_byte_order #(.DATA_W(DATA_W)) u_order (
    .en   (swap_q),
    .din  (packed_word),
    .dout (ordered)
  );

  spk_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (busy_hit),
    .clr   (err_clr),
    .flag  (err_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      swap_q <= 1'b1;
    else if (cfg_we) swap_q <= cfg_swap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= done;
      if (done) word_data <= ordered;
    end
  end

  AST_ISSUE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(out_ready && wr_valid)); // R7
  AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !out_ready) |=> !word_valid); // R7
  AST_BUSY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> err_flag); // R7
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == 2'd3) |=> !word_valid); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !word_valid); // R9
endmodule

// File: tb/subword_packer_test.sv
module subword_packer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic clear = 0, cfg_we = 0, cfg_swap = 0, err_clr = 0;
  logic wr_valid = 0, out_ready = 1;
  logic [1:0] wr_size = 0, wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic err_flag, word_valid;
  logic [31:0] word_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_packer uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_we(cfg_we), .cfg_swap(cfg_swap),
    .err_clr(err_clr), .err_flag(err_flag), .wr_valid(wr_valid), .wr_size(wr_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_ready(out_ready),
    .word_valid(word_valid), .word_data(word_data)
  );

  function automatic logic [31:0] rev4(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic wr(input logic [1:0] sz, input logic [1:0] a, input logic [31:0] d);
    wr_valid = 1; wr_size = sz; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_data = 32'hDEAD_BEEF;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic set_swap(input logic s);
    cfg_we = 1; cfg_swap = s;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, input int lane, input int salt);
    logic [31:0] d;
    d = 32'hA5C3_5A3C ^ (salt * 32'h0101_0101);
    d[8*lane +: 8] = b;
    wr(2'd0, 2'(lane), d);
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 100000 && !finished; cyc++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b [4];
    logic [15:0] h0, h1;
    logic [31:0] w, exp;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(word_valid), 0);
    chk("R1 err after reset", 32'(err_flag), 0);
    wr(2'd2, 2'd0, 32'h1122_3344);
    chk("R1 swap default valid", 32'(word_valid), 1);
    chk("R1 swap default data", word_data, 32'h4433_2211);
    idle();
    chk("R2 single-cycle pulse", 32'(word_valid), 0);

    for (int sw = 1; sw >= 0; sw--) begin
      set_swap(sw[0]);
      for (int k = 0; k < 40; k++) begin   // R4 byte sweep
        for (int i = 0; i < 4; i++) b[i] = 8'((k*37 + i*11 + 5) & 255);
        for (int i = 0; i < 4; i++) begin
          put_byte(b[i], (i + k) % 4, k);
          if (i < 3) chk("R4 no issue before 4th byte", 32'(word_valid), 0);
        end
        exp = {b[3], b[2], b[1], b[0]};
        if (sw == 1) exp = rev4(exp);
        chk("R4 byte issue", 32'(word_valid), 1);
        chk("R4/R5 byte word", word_data, exp);
      end
      for (int k = 0; k < 32; k++) begin   // R3 halfword sweep
        h0 = 16'(k * 16'h1357 + 16'h0F0F);
        h1 = 16'(k * 16'h2468 + 16'hA0A0);
        w = (k % 2) ? {h0, 16'h5555} : {16'h6666, h0};
        wr(2'd1, 2'(2 * (k % 2)), w);
        chk("R3 no issue after first half", 32'(word_valid), 0);
        w = (k % 2) ? {16'h7777, h1} : {h1, 16'h8888};
        wr(2'd1, 2'(2 * ((k + 1) % 2)), w);
        exp = {h1, h0};
        if (sw == 1) exp = rev4(exp);
        chk("R3 half issue", 32'(word_valid), 1);
        chk("R3/R5 half word", word_data, exp);
      end
      for (int k = 0; k < 24; k++) begin   // R2 word sweep
        w = 32'(k) * 32'h9E37_79B9 ^ 32'h0BAD_F00D;
        wr(2'd2, 2'(k), w);
        chk("R2 word issue", 32'(word_valid), 1);
        chk("R2/R5 word data", word_data, sw ? rev4(w) : w);
      end
    end
    set_swap(1'b1);

    // R7: error in mid-word leaves position untouched
    put_byte(8'h10, 0, 1);
    put_byte(8'h20, 1, 2);
    out_ready = 0;
    put_byte(8'hEE, 2, 3);
    chk("R7 no issue while busy", 32'(word_valid), 0);
    chk("R7 err set", 32'(err_flag), 1);
    out_ready = 1;
    put_byte(8'h30, 2, 4);
    chk("R7 no advance on error", 32'(word_valid), 0);
    put_byte(8'h40, 3, 5);
    chk("R7 word after error", word_data, rev4(32'h4030_2010));
    idle(); idle();
    chk("R8 err sticky", 32'(err_flag), 1);
    err_clr = 1; idle(); err_clr = 0;
    chk("R8 err cleared", 32'(err_flag), 0);
    out_ready = 0; err_clr = 1;
    wr(2'd2, 2'd0, 32'h1);
    err_clr = 0; out_ready = 1;
    chk("R8 set beats clear", 32'(err_flag), 1);
    err_clr = 1; idle(); err_clr = 0;

    // R6: reserved size ignored, even while busy
    out_ready = 0;
    wr(2'd3, 2'd0, 32'hFFFF_FFFF);
    chk("R6 reserved no error", 32'(err_flag), 0);
    out_ready = 1;
    put_byte(8'hA1, 0, 6);
    wr(2'd3, 2'd1, 32'h0000_FF00);
    chk("R6 reserved no issue", 32'(word_valid), 0);
    put_byte(8'hA2, 1, 7);
    put_byte(8'hA3, 2, 8);
    put_byte(8'hA4, 3, 9);
    chk("R6 reserved no advance valid", 32'(word_valid), 1);
    chk("R6 reserved no advance data", word_data, rev4(32'hA4A3_A2A1));

    // R9: clear restarts at lane 0, same-cycle write dropped
    put_byte(8'h01, 0, 1);
    put_byte(8'h02, 1, 2);
    clear = 1;
    put_byte(8'h03, 2, 3);
    clear = 0;
    chk("R9 clear drops write", 32'(word_valid), 0);
    for (int i = 0; i < 4; i++) put_byte(8'(8'hC0 + i), i, i);
    chk("R9 word after clear", word_data, rev4(32'hC3C2_C1C0));
    chk("R9 valid after clear", 32'(word_valid), 1);

    // R10: word write mid-pack
    put_byte(8'h55, 0, 1);
    wr(2'd2, 2'd0, 32'hCAFE_0123);
    chk("R10 word mid-pack valid", 32'(word_valid), 1);
    chk("R10 word mid-pack data", word_data, rev4(32'hCAFE_0123));
    for (int i = 0; i < 4; i++) put_byte(8'(8'h70 + i), i, i);
    chk("R10 restart at lane 0", word_data, rev4(32'h7372_7170));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule